// File: doc/BRIEF.md
# Raster Interrupt Generator

This block turns the horizontal and vertical sync pulses of an external CRT controller into a periodic, maskable CPU interrupt. A small line counter advances once per scan line, on each falling edge of horizontal sync. When it completes a full period of 52 lines, it raises a request and starts again from zero. The request stays active until the CPU acknowledges it.

On acknowledge, only the high bit of the line counter is dropped. The next interrupt therefore cannot follow too closely behind one that the CPU serviced late. Vertical sync realigns the counter to the frame. Two line ends after the start of vertical sync, the counter returns to zero. At that point a request is issued only if the counter sat in its lower half, which avoids producing two interrupts close together. Software can also clear the counter at any moment through a strobe that a control-register write generates.

Top module: `raster_irq_gen`

## Requirements
- R1: The counter advances by one for each falling edge of `hsync`. Both sync inputs pass through `SYNC_STAGES` (default 2) flip-flops before edge detection. A falling edge that is driven just before clock edge k therefore acts on the counter at edge k+SYNC_STAGES.
- R2: When an advance would take the counter to `WRAP_AT` (default 52), the counter becomes 0 and a request is raised. The counter never holds a value at or above `WRAP_AT`.
- R3: An acknowledge while a request is pending clears the request. In the same cycle it clears counter bit `ACK_BIT` (default 5, weight 32) and leaves the other counter bits as they were.
- R4: Realignment takes place on the second `hsync` falling edge detected after a `vsync` rising edge. A falling edge detected in the same cycle as the `vsync` rising edge is not counted. A new `vsync` rising edge restarts the wait.
- R5: At realignment the counter becomes 0. If the counter stood at `RESYNC_THRESH` (default 32) or above, no request is raised.
- R6: At realignment, if the counter stood below `RESYNC_THRESH`, a request is raised.
- R7: `cnt_clear` forces the counter to 0. It overrides a wrap or realignment that falls in the same cycle, and no request results from that cycle.
- R8: A raised request stays pending until it is acknowledged. While it is pending, the counter keeps advancing on line ends.
- R9: An acknowledge with no request pending changes neither the request nor the counter.
- R10: `irq_n` is active low. It reads 1 during reset and after reset until the first request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync | input | 1 | Horizontal sync from the CRT controller, active high |
| vsync | input | 1 | Vertical sync from the CRT controller, active high |
| irq_ack | input | 1 | CPU interrupt acknowledge, one cycle per acknowledge |
| cnt_clear | input | 1 | Software counter clear strobe |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The assertions take for granted that each sync level is held for at least one clock, so that an edge out of the input stages lasts exactly one cycle. They also assume that acknowledge and clear are sampled as plain levels on the clock edge. The stimulus drives every input at the falling clock edge and keeps sync levels steady for whole cycles. It deliberately places clears, acknowledges and `vsync` edges on the very cycle in which a line end is consumed, so that the priority rules are exercised as well as the plain counting.

// File: rtl/raster_irq_pkg.sv
package raster_irq_pkg;
   // Events produced by the sync input stages, one cycle wide each.
   typedef struct packed {
      logic line_end;    // hsync falling edge
      logic frame_start; // vsync rising edge
   } sync_evt_t;

   // Outcome of one counter update.
   typedef struct packed {
      logic raise;  // a new request is to be raised
      logic zeroed; // counter returned to zero this cycle
   } cnt_evt_t;

   function automatic int bits_for(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/rig_edge_det.sv
module rig_edge_det #(
   parameter int STAGES      = 2,
   parameter bit DETECT_FALL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic edge_o
);
   localparam int LAST = STAGES;

   logic [LAST:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[LAST-1:0], din};
   end

   generate
      if (DETECT_FALL) begin : g_fall
         assign edge_o = chain_q[LAST] & ~chain_q[LAST-1];
      end else begin : g_rise
         assign edge_o = ~chain_q[LAST] & chain_q[LAST-1];
      end
   endgenerate

   AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |=> !edge_o); // R1
endmodule

// File: rtl/rig_resync_track.sv
module rig_resync_track #(
   parameter int LINES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_start,
   input  logic line_end,
   output logic resync_o
);
   localparam int SW = raster_irq_pkg::bits_for(LINES);
   localparam logic [SW-1:0] LAST_SEEN = SW'(LINES - 1);

   logic          armed_q;
   logic [SW-1:0] seen_q;

   assign resync_o = armed_q & line_end & ~frame_start & (seen_q == LAST_SEEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         seen_q  <= '0;
      end else if (frame_start) begin
         armed_q <= 1'b1;
         seen_q  <= '0;
      end else if (armed_q && line_end) begin
         if (seen_q == LAST_SEEN) armed_q <= 1'b0;
         else                     seen_q  <= seen_q + 1'b1;
      end
   end

   AST_RESYNC_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      resync_o |=> !armed_q); // R4
   AST_RESTART_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (armed_q && seen_q == '0)); // R4
endmodule

// File: rtl/rig_line_counter.sv
module rig_line_counter #(
   parameter int CNT_W         = 6,
   parameter int WRAP_AT       = 52,
   parameter int RESYNC_THRESH = 32,
   parameter int ACK_BIT       = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      line_end,
   input  logic                      resync,
   input  logic                      sw_clear,
   input  logic                      ack_eff,
   output logic                      raise_o
);
   import raster_irq_pkg::*;

   localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(WRAP_AT - 1);
   localparam logic [CNT_W-1:0] THR_VAL  = CNT_W'(RESYNC_THRESH);

   logic [CNT_W-1:0] cnt_q, base, cnt_d;
   cnt_evt_t         evt;

   always_comb begin
      base = cnt_q;
      if (ack_eff) base[ACK_BIT] = 1'b0;
      cnt_d      = base;
      evt.raise  = 1'b0;
      evt.zeroed = 1'b0;
      if (sw_clear) begin
         cnt_d      = '0;
         evt.zeroed = 1'b1;
      end else if (resync) begin
         cnt_d      = '0;
         evt.zeroed = 1'b1;
         evt.raise  = (base < THR_VAL);
      end else if (line_end) begin
         if (base == LAST_VAL) begin
            cnt_d      = '0;
            evt.zeroed = 1'b1;
            evt.raise  = 1'b1;
         end else begin
            cnt_d = base + 1'b1;
         end
      end
   end

   assign raise_o = evt.raise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   AST_BELOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST_VAL); // R2
   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (line_end && !sw_clear && !resync && !ack_eff && cnt_q == LAST_VAL) |=> (cnt_q == '0)); // R2
   AST_ACK_DROPS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_eff && !sw_clear && !resync && !line_end) |=> (!cnt_q[ACK_BIT] && cnt_q[ACK_BIT-1:0] == $past(cnt_q[ACK_BIT-1:0]))); // R3
   AST_RESYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      resync |=> (cnt_q == '0)); // R5
   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clear |=> (cnt_q == '0)); // R7
   AST_CLEAR_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clear |-> !raise_o); // R7
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_end && !resync && !sw_clear && !ack_eff) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/rig_irq_flag.sv
module rig_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic raise,
   input  logic ack,
   output logic pending_o
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= raise | (pend_q & ~ack);
   end

   assign pending_o = pend_q;

   AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !ack) |=> pend_q); // R8
   AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && ack && !raise) |=> !pend_q); // R3
   AST_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q && !raise) |=> !pend_q); // R9
   AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      raise |=> pend_q); // R2
endmodule

// File: rtl/raster_irq_gen.sv
module raster_irq_gen #(
   parameter int CNT_W         = 6,
   parameter int WRAP_AT       = 52,
   parameter int RESYNC_THRESH = 32,
   parameter int ACK_BIT       = 5,
   parameter int RESYNC_LINES  = 2,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hsync,
   input  logic vsync,
   input  logic irq_ack,
   input  logic cnt_clear,
   output logic irq_n
);
   import raster_irq_pkg::*;

   generate
      if (WRAP_AT < 2 || WRAP_AT > (1 << CNT_W)) begin : g_bad_wrap
         $error("WRAP_AT must fit the counter width");
      end
      if (ACK_BIT < 1 || ACK_BIT >= CNT_W) begin : g_bad_ack
         $error("ACK_BIT must lie inside the counter");
      end
      if (RESYNC_THRESH > WRAP_AT) begin : g_bad_thr
         $error("RESYNC_THRESH must not exceed WRAP_AT");
      end
      if (RESYNC_LINES < 1 || SYNC_STAGES < 1) begin : g_bad_cnt
         $error("RESYNC_LINES and SYNC_STAGES must be at least 1");
      end
   endgenerate

   sync_evt_t ev;
   logic      resync, raise, pending, ack_eff;

   rig_edge_det #(.STAGES(SYNC_STAGES), .DETECT_FALL(1'b1)) u_hs_edge (
      .clk(clk), .rst_n(rst_n), .din(hsync), .edge_o(ev.line_end));

   rig_edge_det #(.STAGES(SYNC_STAGES), .DETECT_FALL(1'b0)) u_vs_edge (
      .clk(clk), .rst_n(rst_n), .din(vsync), .edge_o(ev.frame_start));

   rig_resync_track #(.LINES(RESYNC_LINES)) u_track (
      .clk(clk), .rst_n(rst_n), .frame_start(ev.frame_start),
      .line_end(ev.line_end), .resync_o(resync));

   assign ack_eff = irq_ack & pending;

   rig_line_counter #(
      .CNT_W(CNT_W), .WRAP_AT(WRAP_AT),
      .RESYNC_THRESH(RESYNC_THRESH), .ACK_BIT(ACK_BIT)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .line_end(ev.line_end), .resync(resync),
      .sw_clear(cnt_clear), .ack_eff(ack_eff), .raise_o(raise));

   rig_irq_flag u_flag (
      .clk(clk), .rst_n(rst_n), .raise(raise), .ack(irq_ack), .pending_o(pending));

   assign irq_n = ~pending;

   AST_OUT_ACTIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n) |-> $past(raise)); // R10
endmodule

// File: tb/test_raster_irq_gen.sv
module test_raster_irq_gen;
   localparam int SYNC = 2;
   localparam int WRAP = 52;
   localparam int THR  = 32;
   localparam int ABIT = 5;
   localparam int RL   = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic hsync = 1'b0, vsync = 1'b0, ack = 1'b0, clr = 1'b0;
   logic irq_n;

   int vectors = 0, errors = 0;
   string tag = "R10";

   raster_irq_gen i_raster_irq_gen (
      .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
      .irq_ack(ack), .cnt_clear(clr), .irq_n(irq_n));

   always #5 clk = ~clk;

   // behavioural reference
   int m_cnt = 0;
   bit m_pend = 0;
   bit hh[0:SYNC];
   bit vh[0:SYNC];
   bit m_armed = 0;
   int m_seen = 0;

   always @(posedge clk) begin
      bit hf, vr, rs, raise, ae;
      int base;
      if (!rst_n) begin
         m_cnt = 0; m_pend = 0; m_armed = 0; m_seen = 0;
         for (int i = 0; i <= SYNC; i++) begin hh[i] = 0; vh[i] = 0; end
      end else begin
         hf = hh[SYNC] && !hh[SYNC-1];
         vr = !vh[SYNC] && vh[SYNC-1];
         rs = m_armed && hf && !vr && (m_seen == RL - 1);
         if (vr) begin m_armed = 1; m_seen = 0; end
         else if (m_armed && hf) begin
            if (m_seen == RL - 1) m_armed = 0;
            else m_seen++;
         end
         ae = ack && m_pend;
         base = m_cnt;
         if (ae) base = base & ~(1 << ABIT);
         raise = 0;
         if (clr) m_cnt = 0;
         else if (rs) begin m_cnt = 0; raise = (base < THR); end
         else if (hf) begin
            if (base == WRAP - 1) begin m_cnt = 0; raise = 1; end
            else m_cnt = base + 1;
         end else m_cnt = base;
         m_pend = raise || (m_pend && !ack);
         for (int i = SYNC; i > 0; i--) begin hh[i] = hh[i-1]; vh[i] = vh[i-1]; end
         hh[0] = hsync; vh[0] = vsync;
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      vectors++;
      if (irq_n !== !m_pend) begin
         errors++;
         $display("FAIL %s cycle compare: irq_n=%0b expected %0b", tag, irq_n, !m_pend);
      end
   end

   task automatic check(input logic act, input logic exp, input string req);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: irq_n=%0b expected %0b", req, act, exp);
      end
   endtask

   // one line: hsync high 3 cycles, then low 3 cycles; the line end is
   // consumed before the task returns
   task automatic line();
      hsync = 1'b1;
      repeat (3) @(negedge clk);
      hsync = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic lines(input int n);
      for (int i = 0; i < n; i++) line();
   endtask

   task automatic pulse_ack();
      ack = 1'b1; @(negedge clk); ack = 1'b0;
   endtask

   task automatic pulse_clr();
      clr = 1'b1; @(negedge clk); clr = 1'b0;
   endtask

   // line whose falling edge meets a clear in the very cycle it is consumed
   task automatic line_with_clr();
      hsync = 1'b1;
      repeat (3) @(negedge clk);
      hsync = 1'b0;
      repeat (SYNC) @(negedge clk);
      clr = 1'b1; @(negedge clk); clr = 1'b0;
   endtask

   initial begin
      repeat (100000) @(negedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, irq_n=%0b expected finish", irq_n);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(irq_n, 1'b1, "R10 in reset");
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(irq_n, 1'b1, "R10 after reset");

      tag = "R1"; lines(WRAP - 1);
      check(irq_n, 1'b1, "R1 51 lines no request");
      tag = "R2"; line();
      check(irq_n, 1'b0, "R2 request at 52");

      tag = "R8"; lines(10);
      check(irq_n, 1'b0, "R8 held while unacknowledged");
      tag = "R3"; pulse_ack();
      check(irq_n, 1'b1, "R3 ack clears request");
      lines(41);
      check(irq_n, 1'b1, "R8 counter ran while pending");
      line();
      check(irq_n, 1'b0, "R3 low bits kept, wrap after 42 more");

      pulse_ack();
      lines(40);
      pulse_ack();
      check(irq_n, 1'b1, "R9 stray ack keeps request low");
      lines(11);
      check(irq_n, 1'b1, "R9 stray ack kept counter");
      line();
      check(irq_n, 1'b0, "R9 wrap at 52 despite stray ack");

      lines(40);
      pulse_ack();
      lines(WRAP - 9);
      check(irq_n, 1'b1, "R3 bit5 cleared, count 8");
      line();
      check(irq_n, 1'b0, "R3 wrap after 44 lines");
      pulse_ack();

      tag = "R6"; lines(10);
      vsync = 1'b1;
      line();
      check(irq_n, 1'b1, "R4 no realign after one line");
      line();
      check(irq_n, 1'b0, "R6 realign below threshold raises");
      lines(2); vsync = 1'b0;
      pulse_ack();
      lines(WRAP - 3);
      check(irq_n, 1'b1, "R5 count restarted at realign");
      line();
      check(irq_n, 1'b0, "R5 wrap timed from realign");
      pulse_ack();

      tag = "R5"; lines(40);
      vsync = 1'b1;
      lines(2);
      check(irq_n, 1'b1, "R5 realign at 42 suppressed");
      vsync = 1'b0;
      lines(WRAP - 1);
      check(irq_n, 1'b1, "R5 count zeroed at realign");
      line();
      check(irq_n, 1'b0, "R5 next wrap");
      pulse_ack();

      tag = "R7"; lines(30);
      pulse_clr();
      lines(WRAP - 1);
      check(irq_n, 1'b1, "R7 clear restarted count");
      line();
      check(irq_n, 1'b0, "R7 wrap after clear");
      pulse_ack();

      lines(WRAP - 1);
      line_with_clr();
      check(irq_n, 1'b1, "R7 clear beats wrap");
      lines(WRAP - 1);
      check(irq_n, 1'b1, "R7 count zero after collision");
      line();
      check(irq_n, 1'b0, "R7 wrap after collision");
      pulse_ack();

      tag = "R4";
      for (int it = 0; it < 1500; it++) begin
         hsync = $urandom_range(0, 3) != 0 ? ~hsync : hsync;
         if ($urandom_range(0, 60) == 0) vsync = ~vsync;
         ack = ($urandom_range(0, 15) == 0);
         clr = ($urandom_range(0, 200) == 0);
         @(negedge clk);
      end
      ack = 1'b0; clr = 1'b0;
      repeat (5) @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule